// File: doc/BRIEF.md
# SPI Flash Command Frame Engine

This block is an SPI master for serial flash. It drives a whole flash transaction inside a single chip-select window. A transaction starts with one opcode byte. An address of 3 or 4 bytes may follow. Zero-valued dummy bytes come next, then a transmit data phase and then a receive data phase. The requester sets the length of each of these phases per command. The block uses a single data lane in SPI mode 0, and a clock divider sets the serial clock rate.

A requester offers a command on the request port and holds it until the block accepts it. A command is accepted in a cycle where both `req_valid_i` and `req_ready_o` are high. Transmit payload bytes are pulled from `tx_data_i`: the block samples that input in each cycle where `tx_pop_o` pulses. Each received payload byte is presented on `rx_data_o` with a one-cycle `rx_valid_o` strobe. `busy_o` covers the frame, and `done_o` marks the moment chip select returns high.

Top module: `spi_frame_engine`

## Requirements
- R1: After `cs_no` falls, the first byte on `mosi_o` is `req_opcode_i`, and exactly one opcode byte is sent per frame.
- R2: When `req_has_addr_i` is 1, the address follows the opcode, most-significant byte first. It is 4 bytes (`req_addr_i[31:0]`) when `req_addr4_i` is 1, and 3 bytes (`req_addr_i[23:0]`) otherwise.
- R3: After the address come floor(`req_dummy_i`/8) dummy bytes, each 0x00.
- R4: When `req_has_addr_i` is 0, the frame has no address bytes and no dummy bytes, whatever `req_addr_i`, `req_addr4_i` and `req_dummy_i` hold.
- R5: Next come `req_tx_len_i` transmit bytes, taken in order from `tx_data_i`. `tx_pop_o` pulses exactly once per byte, in the cycle the byte is sampled.
- R6: The frame ends with `req_rx_len_i` receive bytes. While they are received, `mosi_o` sends 0x00. Each byte received MSB first is presented on `rx_data_o`, qualified by a one-cycle `rx_valid_o` pulse.
- R7: The link runs in SPI mode 0 and sends data MSB first. `sclk_o` idles low. `mosi_o` does not change while `sclk_o` is high. `miso_i` is sampled on the rising edge of `sclk_o`.
- R8: `cs_no` stays low without a break for the whole frame. The frame has exactly 8 x (total bytes) rising edges of `sclk_o`. Consecutive rising edges are 2 x (`clk_div_i`+1) clock cycles apart, using the `clk_div_i` value sampled when the command is accepted.
- R9: `busy_o` is high from the accepting edge until `cs_no` rises. `done_o` is a single-cycle pulse in the cycle `cs_no` returns high.
- R10: Between two frames, `cs_no` stays high for at least 2 `sclk_o` periods, and `req_ready_o` is low during that interval.
- R11: After reset, `cs_no` is 1, `sclk_o` is 0, `busy_o` and `done_o` are 0, and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command offered |
| req_ready_o | output | 1 | Command can be accepted |
| req_opcode_i | input | 8 | Opcode byte |
| req_addr_i | input | 32 | Flash address |
| req_has_addr_i | input | 1 | Command carries an address and dummy phase |
| req_addr4_i | input | 1 | 1: 4-byte address, 0: 3-byte address |
| req_dummy_i | input | DUMMY_W | Dummy length in clock cycles (sent as whole bytes) |
| req_tx_len_i | input | LEN_W | Transmit payload length in bytes |
| req_rx_len_i | input | LEN_W | Receive payload length in bytes |
| clk_div_i | input | DIV_W | Half-period of SCLK in clock cycles, minus one |
| tx_data_i | input | 8 | Transmit payload byte |
| tx_pop_o | output | 1 | Payload byte sampled this cycle |
| rx_data_o | output | 8 | Received payload byte |
| rx_valid_o | output | 1 | rx_data_o valid this cycle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame finished |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The assertions assume that request fields hold still while `req_valid_i` waits for acceptance. They also assume that `tx_data_i` carries the correct byte in any cycle where `tx_pop_o` may pulse. The assertions on address-phase bounds hold only because `req_addr4_i` selects between exactly 3 and 4 bytes. The stimulus sets every request field at a falling clock edge and drops `req_valid_i` right after acceptance. It draws `tx_data_i` from a bench buffer indexed by a counter of the pops. It keeps `clk_div_i` and the lengths small enough that every frame finishes quickly, and it mixes random commands with directed ones: opcode-only frames, dummy counts that are not multiples of 8, and ignored address fields.

// File: rtl/spi_frame_pkg.sv
`timescale 1ns/1ps
package spi_frame_pkg;
  // phase order after the opcode byte; the sequencer walks it upward
  typedef enum logic [2:0] {
    PH_ADDR  = 3'd0,
    PH_DUMMY = 3'd1,
    PH_TX    = 3'd2,
    PH_RX    = 3'd3,
    PH_END   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_TRAIL,
    ST_GAP
  } state_e;

  localparam int unsigned NUM_PH = 4;
endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || tick_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $stable(div_i) |-> cnt_q <= div_i);
endmodule

// File: rtl/spi_byte_shift.sv
`timescale 1ns/1ps
module spi_byte_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       more_i,
  input  logic [7:0] next_byte_i,
  input  logic       miso_i,
  output logic       take_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic [7:0] tx_sr_q, rx_sr_q;
  logic [3:0] half_q;
  logic       active_q, sclk_q;

  // half 0,2..14: rising edge; half 1..15: falling edge
  assign byte_done_o = active_q && tick_i && (half_q == 4'd15);
  assign take_o      = byte_done_o && more_i;
  assign rx_byte_o   = rx_sr_q;
  assign sclk_o      = sclk_q;
  assign mosi_o      = active_q & tx_sr_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q  <= '0;
      rx_sr_q  <= '0;
      half_q   <= '0;
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
    end else if (load_i) begin
      tx_sr_q  <= load_byte_i;
      half_q   <= '0;
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
    end else if (active_q && tick_i) begin
      if (!half_q[0]) begin
        sclk_q  <= 1'b1;
        rx_sr_q <= {rx_sr_q[6:0], miso_i};
        half_q  <= half_q + 1'b1;
      end else begin
        sclk_q <= 1'b0;
        if (half_q == 4'd15) begin
          half_q <= '0;
          if (more_i) tx_sr_q  <= next_byte_i;
          else        active_q <= 1'b0;
        end else begin
          tx_sr_q <= {tx_sr_q[6:0], 1'b0};
          half_q  <= half_q + 1'b1;
        end
      end
    end
  end

  a_r7_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o));
  a_r7_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sclk_o);
endmodule

// File: rtl/spi_frame_seq.sv
`timescale 1ns/1ps
module spi_frame_seq
  import spi_frame_pkg::*;
#(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned DUMMY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [31:0]        addr_i,
  input  logic               has_addr_i,
  input  logic               addr4_i,
  input  logic [DUMMY_W-1:0] dummy_i,
  input  logic [LEN_W-1:0]   tx_len_i,
  input  logic [LEN_W-1:0]   rx_len_i,
  input  logic               take_i,
  input  logic [7:0]         tx_data_i,
  output logic               more_o,
  output logic [7:0]         next_byte_o,
  output logic               tx_pop_o,
  output logic               cur_rx_o
);
  phase_e           phase_q, eff_ph;
  logic [LEN_W-1:0] cnt_q, eff_cnt, len_v;
  logic [LEN_W-1:0] full_len_q [NUM_PH];
  logic [31:0]      addr_q;
  logic             cur_rx_q, found;
  logic [LEN_W-1:0] addr_len, dummy_len;

  assign addr_len  = has_addr_i ? (addr4_i ? LEN_W'(4) : LEN_W'(3)) : '0;
  assign dummy_len = has_addr_i ? LEN_W'(dummy_i >> 3) : '0;

  // first phase at or after phase_q that still has bytes left
  always_comb begin
    found   = 1'b0;
    eff_ph  = PH_END;
    eff_cnt = '0;
    len_v   = '0;
    for (int i = 0; i < NUM_PH; i++) begin
      len_v = (3'(i) == phase_q) ? cnt_q : full_len_q[i];
      if (!found && (3'(i) >= phase_q) && (len_v != '0)) begin
        found   = 1'b1;
        eff_ph  = phase_e'(3'(i));
        eff_cnt = len_v;
      end
    end
  end

  always_comb begin
    case (eff_ph)
      PH_ADDR: next_byte_o = 8'(addr_q >> {eff_cnt[1:0] - 2'd1, 3'b000});
      PH_TX:   next_byte_o = tx_data_i;
      default: next_byte_o = 8'h00;
    endcase
  end

  assign more_o   = found;
  assign tx_pop_o = take_i && (eff_ph == PH_TX);
  assign cur_rx_o = cur_rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_END;
      cnt_q    <= '0;
      addr_q   <= '0;
      cur_rx_q <= 1'b0;
      for (int i = 0; i < NUM_PH; i++) full_len_q[i] <= '0;
    end else if (start_i) begin
      phase_q       <= PH_ADDR;
      cnt_q         <= addr_len;
      addr_q        <= addr_i;
      cur_rx_q      <= 1'b0;
      full_len_q[0] <= addr_len;
      full_len_q[1] <= dummy_len;
      full_len_q[2] <= tx_len_i;
      full_len_q[3] <= rx_len_i;
    end else if (take_i) begin
      phase_q  <= eff_ph;
      cnt_q    <= eff_cnt - 1'b1;
      cur_rx_q <= (eff_ph == PH_RX);
    end
  end

  a_r2_addr_bytes_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_ADDR |-> cnt_q <= LEN_W'(4));
  a_r6_rx_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_rx_q && !start_i |-> eff_ph inside {PH_RX, PH_END});
endmodule

// File: rtl/spi_frame_engine.sv
`timescale 1ns/1ps
module spi_frame_engine
  import spi_frame_pkg::*;
#(
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned DUMMY_W     = 8,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned CS_GAP_SCLK = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [7:0]         req_opcode_i,
  input  logic [31:0]        req_addr_i,
  input  logic               req_has_addr_i,
  input  logic               req_addr4_i,
  input  logic [DUMMY_W-1:0] req_dummy_i,
  input  logic [LEN_W-1:0]   req_tx_len_i,
  input  logic [LEN_W-1:0]   req_rx_len_i,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic [7:0]         tx_data_i,
  output logic               tx_pop_o,
  output logic [7:0]         rx_data_o,
  output logic               rx_valid_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_no
);
  localparam int unsigned GAP_HALF = 2 * CS_GAP_SCLK;
  localparam int unsigned GAP_W    = $clog2(GAP_HALF + 1);

  state_e           state_q;
  logic [DIV_W-1:0] div_q;
  logic [GAP_W-1:0] gap_q;
  logic             cs_n_q, done_q, rx_valid_q;
  logic [7:0]       rx_data_q;
  logic             accept, tick, take, byte_done, more, cur_rx;
  logic [7:0]       next_byte, rx_byte;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign busy_o      = (state_q == ST_FRAME) || (state_q == ST_TRAIL);
  assign cs_no       = cs_n_q;
  assign done_o      = done_q;
  assign rx_data_o   = rx_data_q;
  assign rx_valid_o  = rx_valid_q;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_IDLE),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_frame_seq #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .addr_i      (req_addr_i),
    .has_addr_i  (req_has_addr_i),
    .addr4_i     (req_addr4_i),
    .dummy_i     (req_dummy_i),
    .tx_len_i    (req_tx_len_i),
    .rx_len_i    (req_rx_len_i),
    .take_i      (take),
    .tx_data_i   (tx_data_i),
    .more_o      (more),
    .next_byte_o (next_byte),
    .tx_pop_o    (tx_pop_o),
    .cur_rx_o    (cur_rx)
  );

  spi_byte_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .load_i      (accept),
    .load_byte_i (req_opcode_i),
    .more_i      (more),
    .next_byte_i (next_byte),
    .miso_i      (miso_i),
    .take_o      (take),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      div_q      <= '0;
      gap_q      <= '0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      rx_valid_q <= byte_done && cur_rx;
      if (byte_done && cur_rx) rx_data_q <= rx_byte;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_FRAME;
          div_q   <= clk_div_i;
          cs_n_q  <= 1'b0;
        end
        ST_FRAME: if (byte_done && !more) state_q <= ST_TRAIL;
        ST_TRAIL: if (tick) begin
          state_q <= ST_GAP;
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          gap_q   <= '0;
        end
        ST_GAP: if (tick) begin
          if (gap_q == GAP_W'(GAP_HALF - 1)) state_q <= ST_IDLE;
          else                               gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_done_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no && $past(!cs_no));
  a_r7_sclk_low_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r10_no_accept_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> !req_ready_o);
  a_r8_cs_low_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cs_no);
  a_r5_pop_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !cs_no && busy_o);
endmodule

// File: tb/tb_spi_frame_engine.sv
`timescale 1ns/1ps
module tb_spi_frame_engine;
  localparam int LEN_W = 12, DUMMY_W = 8, DIV_W = 4;
  localparam real TCK = 5.0;

  logic clk = 0, rst_n = 0;
  always #(TCK/2) clk = ~clk;

  logic               req_valid = 0, has_addr = 0, addr4 = 0;
  logic [7:0]         opcode = 0;
  logic [31:0]        addr = 0;
  logic [DUMMY_W-1:0] dummy = 0;
  logic [LEN_W-1:0]   tx_len = 0, rx_len = 0;
  logic [DIV_W-1:0]   div = 0;
  logic [7:0]         tx_data;
  logic req_ready, tx_pop, rx_valid, busy, done, sclk, mosi, miso, cs_n;
  logic [7:0] rx_data;

  spi_frame_engine #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W), .DIV_W(DIV_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_opcode_i(opcode), .req_addr_i(addr), .req_has_addr_i(has_addr),
    .req_addr4_i(addr4), .req_dummy_i(dummy), .req_tx_len_i(tx_len),
    .req_rx_len_i(rx_len), .clk_div_i(div), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .busy_o(busy), .done_o(done),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n));

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench memories
  logic [7:0] tx_mem [64];
  logic [7:0] slv_mem [64];
  logic [7:0] exp_mem [64];
  string      exp_tag [64];
  logic [7:0] cap [64];
  logic [7:0] rx_got [64];
  int tx_idx = 0, tx_base = 0;
  int ncap = 0, bitcnt = 0, sbit = 0, nrx = 0, cs_falls = 0;
  int period_err = 0, done_cnt = 0, done_err = 0, busy_err = 0;
  logic [7:0] shin = 0;
  realtime last_rise = 0, cs_rise_t = 0;
  bit have_rise = 0;
  int cur_div = 0, prev_div = 0;

  assign tx_data = tx_mem[(tx_idx - tx_base) & 63];
  assign miso    = slv_mem[(sbit >> 3) & 63][7 - (sbit & 7)];
  always @(posedge clk) if (tx_pop) tx_idx <= tx_idx + 1;

  // SPI slave model
  always @(negedge cs_n) begin
    cs_falls++;
    ncap = 0; bitcnt = 0; sbit = 0;
    if (have_rise)
      chk(($realtime - cs_rise_t) >= 4.0 * (prev_div + 1) * TCK, "R10 cs gap",
          longint'($realtime - cs_rise_t), longint'(4.0 * (prev_div + 1) * TCK));
  end
  always @(posedge cs_n) if (rst_n) begin
    cs_rise_t = $realtime; have_rise = 1; prev_div = cur_div;
  end
  always @(posedge sclk) if (!cs_n) begin
    if (bitcnt > 0 && ($realtime - last_rise) != 2.0 * (cur_div + 1) * TCK) period_err++;
    last_rise = $realtime;
    shin = {shin[6:0], mosi};
    bitcnt++;
    if ((bitcnt & 7) == 0) begin cap[ncap & 63] = shin; ncap++; end
  end
  always @(negedge sclk) if (!cs_n) sbit++;

  logic prev_cs = 1;
  always @(negedge clk) begin
    if (rx_valid) begin rx_got[nrx & 63] = rx_data; nrx++; end
    if (done) begin
      done_cnt++;
      if (!(cs_n && !prev_cs && !busy)) done_err++;
    end
    if (!cs_n && !busy) busy_err++;
    prev_cs = cs_n;
  end

  task automatic run(input logic [7:0] op, input logic [31:0] a, input bit ha, input bit a4,
                     input int dm, input int txl, input int rxl, input int dv);
    int n = 0, alen, dlen, pre, falls0;
    alen = ha ? (a4 ? 4 : 3) : 0;
    dlen = ha ? dm / 8 : 0;
    exp_mem[n] = op; exp_tag[n] = "R1 opcode"; n++;
    for (int k = alen - 1; k >= 0; k--) begin
      exp_mem[n] = a[8*k +: 8]; exp_tag[n] = ha ? "R2 address" : "R4"; n++;
    end
    for (int k = 0; k < dlen; k++) begin exp_mem[n] = 8'h00; exp_tag[n] = "R3 dummy"; n++; end
    for (int k = 0; k < txl; k++) begin
      tx_mem[k] = 8'($urandom); exp_mem[n] = tx_mem[k]; exp_tag[n] = "R5 tx data"; n++;
    end
    for (int k = 0; k < rxl; k++) begin exp_mem[n] = 8'h00; exp_tag[n] = "R6 rx mosi"; n++; end
    pre = 1 + alen + dlen;
    for (int k = 0; k < 64; k++) slv_mem[k] = 8'($urandom);
    do @(negedge clk); while (!req_ready);
    tx_base = tx_idx; nrx = 0; done_cnt = 0; done_err = 0; busy_err = 0; period_err = 0;
    falls0 = cs_falls; cur_div = dv;
    opcode = op; addr = a; has_addr = ha; addr4 = a4; dummy = DUMMY_W'(dm);
    tx_len = LEN_W'(txl); rx_len = LEN_W'(rxl); div = DIV_W'(dv); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy && !cs_n, "R9 busy after accept", {busy, cs_n}, 2'b10);
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(ncap == n && bitcnt == 8 * n, "R8 frame bytes", ncap, n);
    chk(cs_falls - falls0 == 1, "R8 one cs window", cs_falls - falls0, 1);
    chk(period_err == 0, "R8/R7 sclk period", period_err, 0);
    for (int k = 0; k < n && k < ncap; k++)
      chk(cap[k] == exp_mem[k], exp_tag[k], cap[k], exp_mem[k]);
    chk(tx_idx - tx_base == txl, "R5 pop count", tx_idx - tx_base, txl);
    chk(nrx == rxl, "R6 rx count", nrx, rxl);
    for (int k = 0; k < rxl && k < nrx; k++)
      chk(rx_got[k] == slv_mem[pre + txl + k], "R6 rx data", rx_got[k], slv_mem[pre + txl + k]);
    chk(done_cnt == 1 && done_err == 0, "R9 done pulse", done_cnt, 1);
    chk(busy_err == 0, "R9 busy cover", busy_err, 0);
    chk(!req_ready || $realtime - cs_rise_t >= 4.0 * (dv + 1) * TCK, "R10 ready in gap",
        req_ready, 0);
  endtask

  initial begin
    #(200000 * TCK);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1, "R11 cs idle", cs_n, 1);
    chk(sclk == 0, "R11 sclk idle", sclk, 0);
    chk(!busy && !done, "R11 busy/done", {busy, done}, 0);
    chk(req_ready == 1, "R11 ready", req_ready, 1);
    // directed corners
    run(8'h06, 32'h0, 0, 0, 0, 0, 0, 0);                 // opcode only
    run(8'h03, 32'hA1B2C3D4, 1, 0, 0, 0, 4, 1);           // R2 3-byte address
    run(8'h0C, 32'hA1B2C3D4, 1, 1, 8, 0, 3, 2);           // R2 4-byte + R3 one dummy
    run(8'h0B, 32'h00123456, 1, 0, 7, 0, 2, 0);           // R3 7 cycles -> no dummy
    run(8'h5A, 32'h00000010, 1, 0, 15, 0, 2, 3);          // R3 15 cycles -> one dummy
    run(8'h9F, 32'hDEADBEEF, 0, 1, 24, 0, 3, 1);          // R4 ignored addr/dummy
    run(8'h02, 32'h00FF0001, 1, 0, 0, 5, 0, 0);           // R5 tx only
    run(8'h01, 32'h0, 0, 0, 0, 2, 2, 1);                  // R5+R6 tx then rx
    for (int t = 0; t < 24; t++)
      run(8'($urandom), $urandom, 1'($urandom), 1'($urandom), int'($urandom_range(0, 31)),
          int'($urandom_range(0, 6)), int'($urandom_range(0, 6)), int'($urandom_range(0, 2)));
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule